// File: doc/BRIEF.md
# Peripheral Bus Command Channel

This block is one host-facing command channel in front of a serial peripheral-bus master. The host first loads up to two 32-bit write-data words. It then writes a single command word that names an internal opcode, a target slave, a register address and a byte count. The write to the command word starts the transaction. The channel decodes the command, drops the fields a given opcode class does not use, and presents the request downstream on a valid/ready handshake.

The downstream master answers some cycles later with a one-cycle response strobe. The strobe carries a 2-bit result code and up to eight returned bytes. The channel folds the result into a four-bit status register. When a read-class transaction succeeds, it also stores the returned bytes into two read-data words, with the unused byte lanes forced to zero.

Only one transaction is ever in flight. A command written while the channel is busy is refused and flagged in the status register. Write-data loads made while busy are also refused.

Top module: `pcc_channel`

## Requirements
- R1: The command word is decoded as opcode = bits 31:27, slave ID = bits 23:20, register address = bits 19:4, and byte count minus one = bits 2:0. While `req_valid` is high, `req_opcode` and `req_sid` carry those fields. For every opcode that is not a control opcode, `req_addr` and `req_bcnt` carry those fields as well.
- R2: Reset clears every register to zero and holds `req_valid` low. A command write (host address 0) made while idle clears the status to 0 and raises `req_valid` on the next cycle. The request and all of its fields then hold steady until a cycle with `req_ready` high.
- R3: For the control opcodes 3, 4, 5 and 6, the request carries only the opcode and slave ID. `req_addr`, `req_bcnt` and `req_wdata` are all zero.
- R4: For the write-class opcodes 0, 2, 9, 14 and 16, `req_wdata` is {data word 1, data word 0}, with byte 0 in bits 7:0. Bytes above the byte count are zero. For every other opcode, `req_wdata` is zero.
- R5: The status bits are: bit 0 done, bit 1 failure, bit 2 denied, bit 3 dropped. On the first cycle of `rsp_valid` after the request handshake, the status becomes done plus a result bit, chosen by the result code:
  - code 00: no error bit;
  - codes 01 and 11: failure;
  - code 10: denied.
- R6: The read-class opcodes are 1, 8, 13 and 15. When one of them completes with code 00, read word 0 takes response bytes 0..3 and read word 1 takes bytes 4..7. Lanes above the byte count read as zero. In every other case, the read words do not change.
- R7: While a transaction is in flight, a command write is not forwarded and does not replace the latched command. It sets the dropped and done status bits (status 0x9 if the status was clear). Write-data loads are also ignored during this time. The in-flight transaction still completes and reports its own status.
- R8: A `rsp_valid` pulse that arrives when no request is waiting for a response has no effect on status, read data or `req_valid`.
- R9: Host register map: address 0 is the command (reads back the latched command), 1 is the status (bits 3:0), 2 and 3 are write-data words 0 and 1, and 4 and 5 are read-data words 0 and 1. `host_rdata` is the combinational read of `host_raddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_waddr | input | 3 | Host write register index |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 3 | Host read register index |
| host_rdata | output | 32 | Host read data |
| req_valid | output | 1 | Downstream request valid |
| req_ready | input | 1 | Downstream request accepted |
| req_opcode | output | 5 | Internal opcode |
| req_sid | output | 4 | Slave ID |
| req_addr | output | 16 | Register address on the slave |
| req_bcnt | output | 3 | Byte count minus one |
| req_wdata | output | 64 | Write bytes, byte 0 lowest |
| rsp_valid | input | 1 | Single-cycle response strobe |
| rsp_code | input | 2 | Result: 00 ok, 01 fail, 10 denied, 11 fail |
| rsp_rdata | input | 64 | Returned read bytes, byte 0 lowest |

## Verification
The bench builds the channel with its default parameters, 32-bit words and two words per direction. This gives all eight byte lanes and every value of the 3-bit count field. Masking can therefore be checked at both ends: a single byte, and a full upper word. The bench drives the downstream side with adjustable ready and response delays. These delays open the windows in which a second command or a data load arrives mid-transaction. The bench also sends a stray response while idle, and covers each result code on both read-class and write-class opcodes.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

   // command word field positions (fixed layout shared with the downstream master)
   localparam int CMD_W   = 32;
   localparam int OP_W    = 5;
   localparam int SID_W   = 4;
   localparam int RA_W    = 16;
   localparam int BC_W    = 3;
   localparam int OP_LSB  = 27;
   localparam int SID_LSB = 20;
   localparam int RA_LSB  = 4;
   localparam int BC_LSB  = 0;

   // status bits
   localparam int ST_W    = 4;
   localparam int ST_DONE = 0;
   localparam int ST_FAIL = 1;
   localparam int ST_DENY = 2;
   localparam int ST_DROP = 3;

   // downstream result codes
   localparam logic [1:0] RC_OK   = 2'b00;
   localparam logic [1:0] RC_FAIL = 2'b01;
   localparam logic [1:0] RC_DENY = 2'b10;
   localparam logic [1:0] RC_BAD  = 2'b11;

   // host register indices
   localparam int REG_CMD  = 0;
   localparam int REG_STAT = 1;
   localparam int REG_WD0  = 2;

   // internal opcodes
   localparam logic [OP_W-1:0] OP_XWR_LONG = 5'd0;
   localparam logic [OP_W-1:0] OP_XRD_LONG = 5'd1;
   localparam logic [OP_W-1:0] OP_XWR      = 5'd2;
   localparam logic [OP_W-1:0] OP_RST      = 5'd3;
   localparam logic [OP_W-1:0] OP_SLP      = 5'd4;
   localparam logic [OP_W-1:0] OP_SHDN     = 5'd5;
   localparam logic [OP_W-1:0] OP_WAKE     = 5'd6;
   localparam logic [OP_W-1:0] OP_AUTH     = 5'd7;
   localparam logic [OP_W-1:0] OP_MRD      = 5'd8;
   localparam logic [OP_W-1:0] OP_MWR      = 5'd9;
   localparam logic [OP_W-1:0] OP_XRD      = 5'd13;
   localparam logic [OP_W-1:0] OP_WR       = 5'd14;
   localparam logic [OP_W-1:0] OP_RD       = 5'd15;
   localparam logic [OP_W-1:0] OP_ZWR      = 5'd16;

   typedef enum logic [1:0] {CL_OTHER, CL_READ, CL_WRITE, CL_CTRL} op_class_e;
   typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT} seq_state_e;

   function automatic op_class_e op_class(input logic [OP_W-1:0] op);
      case (op)
         OP_XRD_LONG, OP_MRD, OP_XRD, OP_RD:       return CL_READ;
         OP_XWR_LONG, OP_XWR, OP_MWR, OP_WR, OP_ZWR: return CL_WRITE;
         OP_RST, OP_SLP, OP_SHDN, OP_WAKE:         return CL_CTRL;
         default:                                  return CL_OTHER;
      endcase
   endfunction

endpackage

// File: rtl/pcc_decode.sv
module pcc_decode
   import pcc_pkg::*;
(
   input  logic [CMD_W-1:0] cmd,
   output logic [OP_W-1:0]  op,
   output logic [SID_W-1:0] sid,
   output logic [RA_W-1:0]  raddr,
   output logic [BC_W-1:0]  bcnt,
   output op_class_e        cls
);
   logic unused_cmd_bits;

   assign op    = cmd[OP_LSB  +: OP_W];
   assign sid   = cmd[SID_LSB +: SID_W];
   assign raddr = cmd[RA_LSB  +: RA_W];
   assign bcnt  = cmd[BC_LSB  +: BC_W];
   assign cls   = op_class(op);

   assign unused_cmd_bits = ^{cmd[26:24], cmd[3]};
endmodule

// File: rtl/pcc_bytemask.sv
module pcc_bytemask #(
   parameter int N_BYTES = 8,
   parameter int CNT_W   = 3
) (
   input  logic [CNT_W-1:0]     bcnt,
   output logic [N_BYTES*8-1:0] mask
);
   genvar b;
   generate
      for (b = 0; b < N_BYTES; b++) begin : g_lane
         assign mask[b*8 +: 8] = {8{(32'(bcnt) >= 32'(b))}};
      end
   endgenerate
endmodule

// File: rtl/pcc_seq.sv
module pcc_seq
   import pcc_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            req_ready,
   input  logic            rsp_valid,
   input  logic [1:0]      rsp_code,
   output logic            req_valid,
   output logic            busy,
   output logic            accept,
   output logic            cpl_ok,
   output logic [ST_W-1:0] status
);
   seq_state_e state, state_n;
   logic       rsp_take, drop;
   logic [ST_W-1:0] status_n;

   assign busy      = (state != SQ_IDLE);
   assign req_valid = (state == SQ_REQ);
   assign accept    = start && !busy;
   assign drop      = start && busy;
   assign rsp_take  = (state == SQ_WAIT) && rsp_valid;
   assign cpl_ok    = rsp_take && (rsp_code == RC_OK);

   always_comb begin
      state_n = state;
      case (state)
         SQ_IDLE: if (accept)    state_n = SQ_REQ;
         SQ_REQ:  if (req_ready) state_n = SQ_WAIT;
         SQ_WAIT: if (rsp_valid) state_n = SQ_IDLE;
         default:                state_n = SQ_IDLE;
      endcase
   end

   always_comb begin
      status_n = status;
      if (accept) status_n = '0;
      if (rsp_take) begin
         status_n          = '0;
         status_n[ST_DONE] = 1'b1;
         status_n[ST_FAIL] = (rsp_code == RC_FAIL) || (rsp_code == RC_BAD);
         status_n[ST_DENY] = (rsp_code == RC_DENY);
      end
      if (drop) begin
         status_n[ST_DROP] = 1'b1;
         status_n[ST_DONE] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         status <= '0;
      end else begin
         state  <= state_n;
         status <= status_n;
      end
   end

   assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state == SQ_IDLE) |=> (status == '0 && req_valid));
   assert_done_on_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_WAIT && rsp_valid) |=> (status[ST_DONE] && state == SQ_IDLE));
   assert_drop_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state != SQ_IDLE) |=> (status[ST_DROP] && status[ST_DONE]));
   assert_stray_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_IDLE && rsp_valid && !start) |=> (state == SQ_IDLE && $stable(status)));
endmodule

// File: rtl/pcc_channel.sv
module pcc_channel
   import pcc_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int N_WORDS = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          host_we,
   input  logic [$clog2(2+2*N_WORDS)-1:0] host_waddr,
   input  logic [WORD_W-1:0]             host_wdata,
   input  logic [$clog2(2+2*N_WORDS)-1:0] host_raddr,
   output logic [WORD_W-1:0]             host_rdata,
   output logic                          req_valid,
   input  logic                          req_ready,
   output logic [4:0]                    req_opcode,
   output logic [3:0]                    req_sid,
   output logic [15:0]                   req_addr,
   output logic [2:0]                    req_bcnt,
   output logic [WORD_W*N_WORDS-1:0]     req_wdata,
   input  logic                          rsp_valid,
   input  logic [1:0]                    rsp_code,
   input  logic [WORD_W*N_WORDS-1:0]     rsp_rdata
);
   localparam int DATA_W  = WORD_W * N_WORDS;
   localparam int N_BYTES = DATA_W / 8;
   localparam int REG_AW  = $clog2(2 + 2*N_WORDS);
   localparam int REG_RD0 = REG_WD0 + N_WORDS;

   generate
      if (WORD_W != CMD_W) begin : g_bad_word
         $error("pcc_channel: WORD_W must equal the 32-bit command width");
      end
      if (N_WORDS < 1 || N_BYTES > (1 << BC_W)) begin : g_bad_words
         $error("pcc_channel: N_WORDS must give 1..8 byte lanes");
      end
   endgenerate

   logic [CMD_W-1:0]  cmd_q;
   logic [DATA_W-1:0] wd_flat, rd_flat, lane_mask;
   logic [ST_W-1:0]   status;
   logic              busy, accept, cpl_ok, cmd_wr;
   logic [OP_W-1:0]   dec_op;
   logic [SID_W-1:0]  dec_sid;
   logic [RA_W-1:0]   dec_addr;
   logic [BC_W-1:0]   dec_bcnt;
   op_class_e         dec_cls;

   assign cmd_wr = host_we && (host_waddr == REG_AW'(REG_CMD));

   pcc_decode u_dec (
      .cmd(cmd_q), .op(dec_op), .sid(dec_sid), .raddr(dec_addr),
      .bcnt(dec_bcnt), .cls(dec_cls)
   );

   pcc_bytemask #(.N_BYTES(N_BYTES), .CNT_W(BC_W)) u_mask (
      .bcnt(dec_bcnt), .mask(lane_mask)
   );

   pcc_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start(cmd_wr), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_code(rsp_code), .req_valid(req_valid),
      .busy(busy), .accept(accept), .cpl_ok(cpl_ok), .status(status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmd_q <= '0;
      else if (accept) cmd_q <= host_wdata;
   end

   genvar w;
   generate
      for (w = 0; w < N_WORDS; w++) begin : g_word
         localparam logic [REG_AW-1:0] WA = REG_AW'(REG_WD0 + w);
         logic [WORD_W-1:0] wq, rq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   wq <= '0;
            else if (host_we && host_waddr == WA && !busy) wq <= host_wdata;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          rq <= '0;
            else if (cpl_ok && dec_cls == CL_READ) rq <= rsp_rdata[w*WORD_W +: WORD_W] & lane_mask[w*WORD_W +: WORD_W];
         end
         assign wd_flat[w*WORD_W +: WORD_W] = wq;
         assign rd_flat[w*WORD_W +: WORD_W] = rq;
      end
   endgenerate

   // downstream request fields
   assign req_opcode = dec_op;
   assign req_sid    = dec_sid;
   assign req_addr   = (dec_cls == CL_CTRL)  ? '0 : dec_addr;
   assign req_bcnt   = (dec_cls == CL_CTRL)  ? '0 : dec_bcnt;
   assign req_wdata  = (dec_cls == CL_WRITE) ? (wd_flat & lane_mask) : '0;

   always_comb begin
      host_rdata = '0;
      if (host_raddr == REG_AW'(REG_CMD))  host_rdata = cmd_q;
      if (host_raddr == REG_AW'(REG_STAT)) host_rdata = WORD_W'(status);
      for (int i = 0; i < N_WORDS; i++) begin
         if (host_raddr == REG_AW'(REG_WD0 + i)) host_rdata = wd_flat[i*WORD_W +: WORD_W];
         if (host_raddr == REG_AW'(REG_RD0 + i)) host_rdata = rd_flat[i*WORD_W +: WORD_W];
      end
   end

   assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid &&
         $stable({req_opcode, req_sid, req_addr, req_bcnt, req_wdata})));
   assert_ctrl_bare_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op_class(req_opcode) == CL_CTRL) |->
         (req_addr == '0 && req_bcnt == '0 && req_wdata == '0));
   assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpl_ok && dec_cls == CL_READ) |=> $stable(rd_flat));
endmodule

// File: tb/sim_pcc_channel.sv
module sim_pcc_channel;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [2:0]  host_waddr = '0;
   logic [31:0] host_wdata = '0;
   logic [2:0]  host_raddr = '0;
   logic [31:0] host_rdata;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [4:0]  req_opcode;
   logic [3:0]  req_sid;
   logic [15:0] req_addr;
   logic [2:0]  req_bcnt;
   logic [63:0] req_wdata;
   logic        rsp_valid = 1'b0;
   logic [1:0]  rsp_code = '0;
   logic [63:0] rsp_rdata = '0;

   pcc_channel #(.WORD_W(32), .N_WORDS(2)) u0 (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
      .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_opcode(req_opcode),
      .req_sid(req_sid), .req_addr(req_addr), .req_bcnt(req_bcnt),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
      .rsp_rdata(rsp_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   function automatic int cls_of(logic [4:0] op);
      if (op == 1 || op == 8 || op == 13 || op == 15) return 1;
      if (op == 0 || op == 2 || op == 9 || op == 14 || op == 16) return 2;
      if (op >= 3 && op <= 6) return 3;
      return 0;
   endfunction

   function automatic logic [63:0] lanes(logic [2:0] bc);
      logic [63:0] m = '0;
      for (int i = 0; i < 8; i++) if (i <= int'(bc)) m[i*8 +: 8] = 8'hFF;
      return m;
   endfunction

   int          m_st;
   logic [31:0] m_cmd, m_wd0, m_wd1, m_rd0, m_rd1;
   logic [3:0]  m_stat;
   bit          t_rsp, t_acc, t_drop;
   logic [3:0]  t_s;
   logic [63:0] t_d;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cmd = 0; m_wd0 = 0; m_wd1 = 0; m_rd0 = 0; m_rd1 = 0; m_stat = 0;
      end else begin
         t_rsp  = (m_st == 2) && rsp_valid;
         t_acc  = host_we && host_waddr == 0 && m_st == 0;
         t_drop = host_we && host_waddr == 0 && m_st != 0;
         t_s = m_stat;
         if (t_acc) t_s = 0;
         if (t_rsp) t_s = {1'b0, rsp_code == 2, rsp_code == 1 || rsp_code == 3, 1'b1};
         if (t_drop) t_s = t_s | 4'b1001;
         if (t_rsp && rsp_code == 0 && cls_of(m_cmd[31:27]) == 1) begin
            t_d = rsp_rdata & lanes(m_cmd[2:0]);
            m_rd0 = t_d[31:0];
            m_rd1 = t_d[63:32];
         end
         if (host_we && m_st == 0 && host_waddr == 2) m_wd0 = host_wdata;
         if (host_we && m_st == 0 && host_waddr == 3) m_wd1 = host_wdata;
         if (t_acc) begin m_cmd = host_wdata; m_st = 1; end
         else if (m_st == 1 && req_ready) m_st = 2;
         else if (t_rsp) m_st = 0;
         m_stat = t_s;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R2 req_valid", {63'b0, req_valid}, {63'b0, m_st == 1});
         if (m_st == 1) begin
            chk("R1 req_opcode", 64'(req_opcode), 64'(m_cmd[31:27]));
            chk("R1 req_sid", 64'(req_sid), 64'(m_cmd[23:20]));
            if (cls_of(m_cmd[31:27]) == 3) begin
               chk("R3 req_addr", 64'(req_addr), 64'd0);
               chk("R3 req_bcnt", 64'(req_bcnt), 64'd0);
            end else begin
               chk("R1 req_addr", 64'(req_addr), 64'(m_cmd[19:4]));
               chk("R1 req_bcnt", 64'(req_bcnt), 64'(m_cmd[2:0]));
            end
            chk("R4 req_wdata", req_wdata,
                (cls_of(m_cmd[31:27]) == 2) ? ({m_wd1, m_wd0} & lanes(m_cmd[2:0])) : 64'd0);
         end
         case (host_raddr)
            3'd0: chk("R9 command readback", 64'(host_rdata), 64'(m_cmd));
            3'd1: chk("R5 status", 64'(host_rdata), 64'(m_stat));
            3'd2: chk("R9 data word 0", 64'(host_rdata), 64'(m_wd0));
            3'd3: chk("R9 data word 1", 64'(host_rdata), 64'(m_wd1));
            3'd4: chk("R6 read word 0", 64'(host_rdata), 64'(m_rd0));
            3'd5: chk("R6 read word 1", 64'(host_rdata), 64'(m_rd1));
            default: ;
         endcase
      end
   end

   // ---------------- downstream responder ----------------
   int          rdy_lat = 0;
   int          rsp_lat = 1;
   int          rdy_wait = 0;
   int          rsp_wait = 0;
   logic [1:0]  cfg_code = 2'b00;
   logic [63:0] cfg_data = '0;
   bit          inject = 0;

   initial begin
      forever begin
         @(posedge clk); #2;
         rsp_valid = 1'b0;
         req_ready = 1'b0;
         if (inject) begin
            rsp_valid = 1'b1; rsp_code = cfg_code; rsp_rdata = cfg_data; inject = 0;
         end else if (rsp_wait > 0) begin
            rsp_wait--;
            if (rsp_wait == 0) begin
               rsp_valid = 1'b1; rsp_code = cfg_code; rsp_rdata = cfg_data;
            end
         end else if (req_valid) begin
            if (rdy_wait > 0) rdy_wait--;
            else begin req_ready = 1'b1; rsp_wait = rsp_lat; end
         end
      end
   end

   // ---------------- host tasks ----------------
   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(posedge clk); #2;
      host_we = 1'b1; host_waddr = a; host_wdata = d;
      @(posedge clk); #2;
      host_we = 1'b0;
   endtask

   function automatic logic [31:0] mk(int op, int sid, int addr, int bc);
      return (32'(op) << 27) | (32'(sid & 15) << 20) | (32'(addr & 16'hFFFF) << 4) | 32'(bc & 7);
   endfunction

   task automatic issue(logic [31:0] c);
      rdy_wait = rdy_lat;
      wr(3'd0, c);
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (m_st != 0);
      @(negedge clk);
   endtask

   task automatic rd_chk(logic [2:0] a, logic [31:0] exp, string tag);
      @(posedge clk); #2;
      host_raddr = a;
      @(negedge clk);
      chk(tag, 64'(host_rdata), 64'(exp));
   endtask

   task automatic run(logic [31:0] c, logic [1:0] code, logic [63:0] data);
      cfg_code = code; cfg_data = data;
      issue(c);
      wait_idle();
   endtask

   task automatic finish_run();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_err++;
      $display("FAIL watchdog: actual still running expected finished");
      finish_run();
   end

   int ops[14] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 13, 14, 15, 16};

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R9 reset values
      for (int a = 0; a < 6; a++) rd_chk(3'(a), 32'h0, "R9 reset register value");
      chk("R2 reset req_valid", 64'(req_valid), 64'd0);

      // R4/R1 full 8-byte write
      host_raddr = 3'd1;
      wr(3'd2, 32'h44332211);
      wr(3'd3, 32'h88776655);
      run(mk(14, 5, 16'h1234, 7), 2'b00, 64'h0);
      rd_chk(3'd1, 32'h1, "R5 done without error");
      // R4 masked writes
      run(mk(0, 9, 16'hBEEF, 2), 2'b00, 64'h0);
      run(mk(16, 1, 16'h0001, 0), 2'b00, 64'h0);
      rdy_lat = 3; rsp_lat = 4;
      run(mk(9, 15, 16'hFFFF, 4), 2'b00, 64'h0);
      run(mk(2, 3, 16'h8000, 6), 2'b00, 64'h0);
      rdy_lat = 0; rsp_lat = 1;

      // R6 read with partial lanes
      run(mk(15, 4, 16'h0042, 5), 2'b00, 64'hFFEEDDCC_BBAA9988);
      rd_chk(3'd4, 32'hBBAA9988, "R6 read word 0");
      rd_chk(3'd5, 32'h0000DDCC, "R6 upper lanes zero");
      // R5 error codes, R6 no update
      run(mk(13, 2, 16'h0010, 7), 2'b01, 64'h12121212_34343434);
      rd_chk(3'd1, 32'h3, "R5 failure code 01");
      rd_chk(3'd4, 32'hBBAA9988, "R6 unchanged after failed read");
      run(mk(1, 2, 16'h0010, 7), 2'b10, 64'h12121212_34343434);
      rd_chk(3'd1, 32'h5, "R5 denied code 10");
      run(mk(8, 2, 16'h0010, 7), 2'b11, 64'h12121212_34343434);
      rd_chk(3'd1, 32'h3, "R5 code 11 reported as failure");
      rd_chk(3'd5, 32'h0000DDCC, "R6 unchanged after refused read");
      run(mk(1, 7, 16'h0020, 0), 2'b00, 64'h11223344_55667788);
      rd_chk(3'd4, 32'h00000088, "R6 single byte lane");
      rd_chk(3'd5, 32'h0, "R6 single byte upper word zero");
      run(mk(8, 7, 16'h0020, 7), 2'b00, 64'hCAFEF00D_12345678);
      rd_chk(3'd5, 32'hCAFEF00D, "R6 full upper word");
      run(mk(14, 7, 16'h0021, 1), 2'b01, 64'hDEADDEAD_DEADDEAD);
      rd_chk(3'd4, 32'h12345678, "R6 write completion leaves read data");

      // R3 control opcode with stray address/count bits
      rdy_lat = 3;
      cfg_code = 2'b00;
      issue(mk(3, 2, 16'hABCD, 5));
      do @(negedge clk); while (!req_valid);
      chk("R3 control addr zero", 64'(req_addr), 64'd0);
      chk("R3 control count zero", 64'(req_bcnt), 64'd0);
      chk("R3 control data zero", req_wdata, 64'd0);
      chk("R1 control slave id", 64'(req_sid), 64'd2);
      wait_idle();
      rdy_lat = 0;
      run(mk(5, 11, 16'h1111, 7), 2'b00, 64'h0);
      run(mk(7, 6, 16'h2222, 3), 2'b00, 64'h0);

      // R7 command and data load while busy
      wr(3'd2, 32'hA5A5A5A5);
      rsp_lat = 10;
      cfg_code = 2'b00;
      issue(mk(14, 1, 16'h0300, 3));
      wr(3'd0, mk(15, 9, 16'h0400, 7));
      wr(3'd2, 32'h5A5A5A5A);
      rd_chk(3'd1, 32'h9, "R7 dropped and done flagged");
      rd_chk(3'd0, mk(14, 1, 16'h0300, 3), "R7 latched command kept");
      wait_idle();
      rd_chk(3'd1, 32'h1, "R7 in-flight result reported");
      rd_chk(3'd2, 32'hA5A5A5A5, "R7 data load ignored while busy");
      rsp_lat = 1;

      // R8 stray response while idle
      cfg_code = 2'b10; cfg_data = 64'h99999999_99999999;
      @(posedge clk); #2 inject = 1;
      repeat (3) @(negedge clk);
      chk("R8 no request started", 64'(req_valid), 64'd0);
      rd_chk(3'd1, 32'h1, "R8 status unchanged");
      rd_chk(3'd4, 32'h12345678, "R8 read data unchanged");

      // mixed traffic
      host_raddr = 3'd1;
      for (int n = 0; n < 60; n++) begin
         rdy_lat = $urandom_range(0, 3);
         rsp_lat = $urandom_range(1, 4);
         wr(3'd2, $urandom);
         wr(3'd3, $urandom);
         host_raddr = 3'($urandom_range(0, 5));
         run(mk(ops[$urandom_range(0, 13)], $urandom_range(0, 15),
                $urandom_range(0, 65535), $urandom_range(0, 7)),
             2'($urandom_range(0, 3)), {$urandom, $urandom});
      end
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule